// File: doc/BRIEF.md
# Thermometer Edge Position Encoder

This block sits behind a bank of equally spaced delay taps that all sample one signal with a single clock. Each cycle it receives a 16-bit capture word. When a signal edge falls inside the sampling period, the word holds a run of ones at one end and a run of zeros at the other. The block finds out whether such an edge is present and whether it was rising or falling, and it turns the position of the one/zero boundary into a 4-bit fine-time value. A coarse clock counter elsewhere supplies the rest of the timestamp.

A calibrated phase offset, written through a small write port, rotates the word before any decision is made. This aligns tap 0 with the effective sampling edge. One misplaced sample next to the boundary is removed by a three-tap majority filter, so a slightly disordered capture still gives a single index. Falling edges are inverted into the rising form, which lets one encoder serve both polarities. The result is registered and appears one clock after the word is presented.

Top module: `therm_edge_encoder`

## Requirements
- R1: While `rst_n` is low, `edge_valid`, `edge_fall` and `fine_idx` are 0 and the rotation offset is 0. The first word after reset is therefore decoded with no rotation.
- R2: The decoded word is the rotated capture, where bit i equals `sample_i[(i + offset) mod 16]`. Writing `offset_wdata` with `offset_we` high changes the offset used from the next cycle's word onward. A word presented in the same cycle as the write still uses the old offset.
- R3: `edge_valid` is 1 exactly one cycle after a word whose rotated bit 0 differs from its rotated bit 15.
- R4: With `edge_valid` high, `edge_fall` is 0 when rotated bit 0 was 1 (and bit 15 was 0), and 1 when rotated bit 0 was 0 (and bit 15 was 1).
- R5: For a clean word, `fine_idx` is the lowest bit position whose value differs from rotated bit 0. Its range is 1 to 15, and both ends occur.
- R6: Before the index is located, each interior bit of the polarity-normalised word is replaced by the majority of itself and its two neighbours, and the end bits pass through unchanged. A single isolated misplaced bit next to the boundary therefore yields one well-defined index.
- R7: A cycle after a word with equal end bits, `edge_valid`, `edge_fall` and `fine_idx` are all 0.
- R8: Words presented on consecutive cycles each produce their own result one cycle later, with no dropped or merged results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 16 | Capture word from the delay taps |
| offset_we | input | 1 | Load enable for the rotation offset |
| offset_wdata | input | 4 | New rotation offset |
| edge_valid | output | 1 | An edge was found in the previous cycle's word |
| edge_fall | output | 1 | The found edge was falling |
| fine_idx | output | 4 | Boundary position of the found edge |

## Verification
An offset write and an incoming capture word can arrive in the same cycle. The bench provokes this by issuing a write together with a thermometer word, then repeating the same word in the next cycle. The scoreboard's model applies the old offset to the first word and the new offset to the second. The two results differ in polarity and index, so any early or late switch of the offset shows up as a mismatch.

// File: rtl/tdl_enc_pkg.sv
package tdl_enc_pkg;
  parameter int unsigned TAPS_DEF = 16;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic int unsigned wrap_add(input int unsigned a, input int unsigned b,
                                           input int unsigned m);
    int unsigned s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction
endpackage

// File: rtl/tdl_rotator.sv
module tdl_rotator #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  input  logic [SW-1:0] shift_i,
  output logic [W-1:0]  word_o
);
  import tdl_enc_pkg::*;

  always_comb begin
    int unsigned k;
    for (int i = 0; i < W; i++) begin
      k = wrap_add(i, int'(shift_i), W);
      word_o[i] = word_i[k];
    end
  end
endmodule

// File: rtl/tdl_bubble_filter.sv
module tdl_bubble_filter #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  import tdl_enc_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0 || i == W - 1) begin : g_end
      assign word_o[i] = word_i[i];
    end else begin : g_mid
      assign word_o[i] = maj3(word_i[i-1], word_i[i], word_i[i+1]);
    end
  end
endmodule

// File: rtl/tdl_first_zero.sv
module tdl_first_zero #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 1; i--) begin
      if (!word_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/therm_edge_encoder.sv
module therm_edge_encoder #(
  parameter int unsigned W  = tdl_enc_pkg::TAPS_DEF,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  sample_i,
  input  logic          offset_we,
  input  logic [IW-1:0] offset_wdata,
  output logic          edge_valid,
  output logic          edge_fall,
  output logic [IW-1:0] fine_idx
);
  logic [IW-1:0] offset_q;
  logic [W-1:0]  rot_word;
  logic [W-1:0]  norm_word;
  logic [W-1:0]  filt_word;
  logic [IW-1:0] raw_idx;
  logic          edge_seen;
  logic          is_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         offset_q <= '0;
    else if (offset_we) offset_q <= offset_wdata;
  end

  tdl_rotator #(.W(W), .SW(IW)) u_rot (
    .word_i (sample_i),
    .shift_i(offset_q),
    .word_o (rot_word)
  );

  assign edge_seen = rot_word[0] ^ rot_word[W-1];
  assign is_fall   = ~rot_word[0];
  assign norm_word = is_fall ? ~rot_word : rot_word;

  tdl_bubble_filter #(.W(W)) u_filt (
    .word_i(norm_word),
    .word_o(filt_word)
  );

  tdl_first_zero #(.W(W), .IW(IW)) u_enc (
    .word_i(filt_word),
    .idx_o (raw_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_valid <= 1'b0;
      edge_fall  <= 1'b0;
      fine_idx   <= '0;
    end else begin
      edge_valid <= edge_seen;
      edge_fall  <= edge_seen & is_fall;
      fine_idx   <= edge_seen ? raw_idx : '0;
    end
  end
endmodule

// File: rtl/tdl_enc_checker.sv
module tdl_enc_checker #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          offset_we,
  input logic [IW-1:0] offset_wdata,
  input logic [IW-1:0] offset_q,
  input logic [W-1:0]  rot_word,
  input logic          edge_valid,
  input logic          edge_fall,
  input logic [IW-1:0] fine_idx
);
  a_r2_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
    offset_we |=> offset_q == $past(offset_wdata));

  a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !offset_we |=> $stable(offset_q));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> edge_valid == ($past(rot_word[0]) != $past(rot_word[W-1])));

  a_r4_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (edge_valid -> (edge_fall == !$past(rot_word[0]))));

  a_r5_idx_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> fine_idx != '0);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_valid |-> (fine_idx == '0 && !edge_fall));
endmodule

bind therm_edge_encoder tdl_enc_checker #(.W(W), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .offset_we   (offset_we),
  .offset_wdata(offset_wdata),
  .offset_q    (offset_q),
  .rot_word    (rot_word),
  .edge_valid  (edge_valid),
  .edge_fall   (edge_fall),
  .fine_idx    (fine_idx)
);

// File: tb/therm_edge_encoder_test.sv
module therm_edge_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample_i = '0;
  logic        offset_we = 1'b0;
  logic [3:0]  offset_wdata = '0;
  logic        edge_valid;
  logic        edge_fall;
  logic [3:0]  fine_idx;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] mdl_off = '0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  therm_edge_encoder uut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
    .offset_we(offset_we), .offset_wdata(offset_wdata),
    .edge_valid(edge_valid), .edge_fall(edge_fall), .fine_idx(fine_idx)
  );

  // Reference: {valid, fall, idx}
  function automatic logic [5:0] model(input logic [15:0] s, input logic [3:0] off);
    logic [31:0] dbl;
    logic [15:0] r, n, f;
    int first;
    dbl = {s, s} >> off;
    r = dbl[15:0];
    if (r[0] == r[15]) return 6'd0;
    n = r[0] ? r : ~r;
    for (int i = 0; i < 16; i++) begin
      if (i == 0 || i == 15) f[i] = n[i];
      else f[i] = (n[i-1] + n[i] + n[i+1]) >= 2;
    end
    first = 0;
    for (int i = 1; i < 16; i++) if (first == 0 && f[i] == 1'b0) first = i;
    return {1'b1, ~r[0], 4'(first)};
  endfunction

  task automatic drive(input logic [15:0] s, input logic we, input logic [3:0] wd,
                       input string tag);
    @(negedge clk);
    sample_i = s;
    offset_we = we;
    offset_wdata = wd;
    exp_q.push_back(model(s, mdl_off));
    tag_q.push_back(tag);
    if (we) mdl_off = wd;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if ({edge_valid, edge_fall, fine_idx} !== e) begin
        n_fail++;
        $display("FAIL %s: got v=%b f=%b idx=%0d expected v=%b f=%b idx=%0d",
                 t, edge_valid, edge_fall, fine_idx, e[5], e[4], e[3:0]);
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if ({edge_valid, edge_fall, fine_idx} !== 6'd0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got %b expected 000000",
               {edge_valid, edge_fall, fine_idx});
    end
    rst_n = 1'b1;

    drive(16'h00FF, 1'b0, 4'd0, "R1 zero offset after reset");
    // R5 clean rising / falling sweep, R8 back-to-back
    for (int p = 1; p < 16; p++) begin
      drive(16'((32'd1 << p) - 1), 1'b0, 4'd0, "R5 rising clean index");
      drive(~16'((32'd1 << p) - 1), 1'b0, 4'd0, "R4 falling clean index");
    end
    // R7 no edge
    drive(16'h0000, 1'b0, 4'd0, "R7 all zero");
    drive(16'hFFFF, 1'b0, 4'd0, "R7 all one");
    drive(16'h0FF0, 1'b0, 4'd0, "R7 equal ends");
    drive(16'h000F, 1'b0, 4'd0, "R8 edge after idle");
    // R6 bubbles
    for (int p = 3; p < 14; p++) begin
      drive(16'((32'd1 << p) - 1) & ~16'(32'd1 << (p - 2)), 1'b0, 4'd0, "R6 hole in ones");
      drive(16'((32'd1 << p) - 1) | 16'(32'd1 << (p + 1)), 1'b0, 4'd0, "R6 island one");
      drive(~(16'((32'd1 << p) - 1) | 16'(32'd1 << (p + 1))), 1'b0, 4'd0, "R6 falling island");
    end
    drive(16'b0000000001011111, 1'b0, 4'd0, "R6 example bubble");
    // R2 offset write coinciding with a sample
    drive(16'h000F, 1'b1, 4'd4, "R2 old offset same cycle");
    drive(16'h000F, 1'b0, 4'd0, "R2 new offset next cycle");
    for (int o = 0; o < 16; o++) begin
      drive(16'h0000, 1'b1, 4'(o), "R7 idle during offset write");
      drive(16'h003F, 1'b0, 4'd0, "R2 rotated rising");
      drive(16'hF800, 1'b0, 4'd0, "R2 rotated falling");
      drive(16'h0FF0, 1'b0, 4'd0, "R2 rotated band");
    end
    drive(16'h0000, 1'b1, 4'd0, "R7 restore offset");
    drive(16'h7FFF, 1'b0, 4'd0, "R5 index 15");
    drive(16'h0001, 1'b0, 4'd0, "R5 index 1");
    @(negedge clk);
    offset_we = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule